// File: doc/BRIEF.md
# Processor Reset Trap Controller

This block sits beside a processor core and decides what happens when a reset source or a trap request arrives. It watches five sources: the release of power-on reset, an active-low external reset pin, a watchdog timeout pulse, a software reset strobe and ordinary trap requests. It also keeps the current trap level, which has a ceiling of 5. For every accepted event it picks one of three outcomes. It can take a reset trap that vectors into a reset handler. It can divert the core into error_state. Or it can pass the request on as a normal trap.

A reset trap vectors to a configurable base address plus an offset of 32 times the trap type. The outcome depends on the trap level. At the ceiling, ordinary traps and software resets go to error_state and keep their own type code. A watchdog timeout at the ceiling, or a second timeout below it, raises a watchdog reset. error_state lasts a fixed number of cycles and then ends in a watchdog reset. The trap level can be loaded from outside, which models software changing it. A load also clears the RED_state flag.

All outputs are registered. An event sampled at a clock edge shows at the outputs right after that edge, as a one-cycle `trap_valid` pulse.

Top module: `reset_trap_ctrl`

## Requirements
- R1: After synchronous reset, trap_valid, red_state and error_state are 0 and trap_level is 0.
- R2: A falling edge on por_hold gives a reset trap: trap_kind 1 (reset), trap_type 1, vector base+0x20, red_state 1, trap_level 5. Holding por_hold high gives no trap.
- R3: A falling edge on ext_rst_n gives a reset trap with type 3 and vector base+0x60, and sets red_state. Keeping the pin low gives no further trap.
- R4: A software reset strobe with trap_level below 5 gives a reset trap with type 4 and vector base+0x80.
- R5: A software reset strobe with trap_level equal to 5 gives an error-entry pulse: trap_kind 2 (error), type 4. It also sets error_state.
- R6: An ordinary trap request below level 5 passes through: trap_kind 0 (normal), type equal to trap_tt, vector 0. trap_level goes up by one.
- R7: An ordinary trap request at level 5 gives an error-entry pulse that keeps trap_tt as its type, and sets error_state.
- R8: The first watchdog timeout below level 5 is a normal trap with type WDOG_TT, and trap_level goes up by one. The next timeout gives a watchdog reset: type 2, vector base+0x40.
- R9: A watchdog timeout at level 5 gives a watchdog reset at once.
- R10: error_state lasts exactly ERR_CYCLES cycles and then ends with a watchdog reset (type 2, base+0x40). While it lasts, watchdog, software reset and trap requests are ignored.
- R11: When sources arrive together, the priority is power-on release, then external reset, then watchdog, then software reset, then ordinary trap. Exactly one trap_valid pulse is produced.
- R12: Any reset trap clears the pending watchdog flag, so a later timeout below level 5 is again treated as a first timeout.
- R13: tl_load loads tl_value, clamped to 5, and clears red_state. The load is ignored in a cycle that accepts an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_base | input | AW | Reset vector base address |
| por_hold | input | 1 | High while power-on reset is held |
| ext_rst_n | input | 1 | External reset request, active low |
| wdog_tmo | input | 1 | Watchdog timeout pulse |
| sir_req | input | 1 | Software reset strobe |
| trap_req | input | 1 | Ordinary trap request strobe |
| trap_tt | input | 8 | Type code of the ordinary trap |
| tl_load | input | 1 | Load the trap level |
| tl_value | input | TL_W | Trap level to load |
| trap_valid | output | 1 | One-cycle pulse per accepted event |
| trap_kind | output | 2 | 0 normal, 1 reset, 2 error entry |
| trap_type | output | 8 | Trap type code |
| trap_vector | output | AW | Reset vector, 0 for other kinds |
| red_state | output | 1 | RED_state flag |
| error_state | output | 1 | error_state flag |
| trap_level | output | TL_W | Current trap level |

## Verification
Each source is applied alone at a level below the ceiling and again at the ceiling. This separates the reset, error and pass-through outcomes for the same request. Watchdog pulses are sent in pairs, and also with a reset trap between them, to show how the pending flag tells a first timeout from a second. Sources are also raised together in groups that drop the top source one at a time, which exposes each step of the priority order. error_state is timed cycle by cycle, and other requests are sent during it to show they have no effect.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TT_W = 8;

  typedef enum logic [1:0] {
    KIND_NORMAL = 2'd0,
    KIND_RESET  = 2'd1,
    KIND_ERROR  = 2'd2
  } trap_kind_e;

  localparam logic [TT_W-1:0] TT_POR = 8'd1;
  localparam logic [TT_W-1:0] TT_WDR = 8'd2;
  localparam logic [TT_W-1:0] TT_XIR = 8'd3;
  localparam logic [TT_W-1:0] TT_SIR = 8'd4;

  // Reset vectors are spaced 32 bytes apart, indexed by trap type
  localparam int VEC_SHIFT = 5;

  typedef struct packed {
    logic            fire;
    trap_kind_e      kind;
    logic [TT_W-1:0] tt;
    logic            from_wdog;
  } verdict_t;
endpackage

// File: rtl/rtc_edge.sv
module rtc_edge #(
  parameter bit FALLING = 1'b1,
  parameter bit IDLE    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= din;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = prev & ~din;
    end else begin : g_rise
      assign pulse = ~prev & din;
    end
  endgenerate
endmodule

// File: rtl/rtc_err_timer.sv
module rtc_err_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CW'(LIMIT - 1));

  // R10: expiry always ends the error interval on the next cycle
  assert_timer_ends_error_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !run);
  assert_timer_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/rtc_arbiter.sv
module rtc_arbiter
  import rtc_pkg::*;
#(
  parameter int              TL_W    = 3,
  parameter int              MAX_TL  = 5,
  parameter logic [TT_W-1:0] WDOG_TT = 8'h46
) (
  input  logic            por_ev,
  input  logic            xir_ev,
  input  logic            wd_ev,
  input  logic            sir_ev,
  input  logic            trq_ev,
  input  logic [TT_W-1:0] trq_tt,
  input  logic [TL_W-1:0] tl,
  input  logic            wd_pend,
  input  logic            in_err,
  input  logic            err_done,
  output verdict_t        v
);
  localparam logic [TL_W-1:0] TL_MAX = TL_W'(MAX_TL);
  logic at_max;

  assign at_max = (tl >= TL_MAX);

  always_comb begin
    v = '0;
    if (por_ev) begin
      v.fire = 1'b1; v.kind = KIND_RESET; v.tt = TT_POR;
    end else if (xir_ev) begin
      v.fire = 1'b1; v.kind = KIND_RESET; v.tt = TT_XIR;
    end else if (in_err) begin
      if (err_done) begin
        v.fire = 1'b1; v.kind = KIND_RESET; v.tt = TT_WDR;
      end
    end else if (wd_ev) begin
      v.fire = 1'b1;
      if (at_max || wd_pend) begin
        v.kind = KIND_RESET; v.tt = TT_WDR;
      end else begin
        v.kind = KIND_NORMAL; v.tt = WDOG_TT; v.from_wdog = 1'b1;
      end
    end else if (sir_ev) begin
      v.fire = 1'b1; v.tt = TT_SIR;
      v.kind = at_max ? KIND_ERROR : KIND_RESET;
    end else if (trq_ev) begin
      v.fire = 1'b1; v.tt = trq_tt;
      v.kind = at_max ? KIND_ERROR : KIND_NORMAL;
    end
  end
endmodule

// File: rtl/reset_trap_ctrl.sv
module reset_trap_ctrl
  import rtc_pkg::*;
#(
  parameter int              AW         = 32,
  parameter int              TL_W       = 3,
  parameter int              MAX_TL     = 5,
  parameter int              ERR_CYCLES = 8,
  parameter logic [TT_W-1:0] WDOG_TT    = 8'h46
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   rst_base,
  input  logic            por_hold,
  input  logic            ext_rst_n,
  input  logic            wdog_tmo,
  input  logic            sir_req,
  input  logic            trap_req,
  input  logic [TT_W-1:0] trap_tt,
  input  logic            tl_load,
  input  logic [TL_W-1:0] tl_value,
  output logic            trap_valid,
  output logic [1:0]      trap_kind,
  output logic [TT_W-1:0] trap_type,
  output logic [AW-1:0]   trap_vector,
  output logic            red_state,
  output logic            error_state,
  output logic [TL_W-1:0] trap_level
);
  localparam logic [TL_W-1:0] TL_MAX = TL_W'(MAX_TL);

  logic     por_ev, xir_ev, err_done, wd_pend;
  verdict_t v;

  rtc_edge #(.FALLING(1'b1), .IDLE(1'b0)) u_por_edge (
    .clk(clk), .rst(rst), .din(por_hold), .pulse(por_ev));

  rtc_edge #(.FALLING(1'b1), .IDLE(1'b1)) u_xir_edge (
    .clk(clk), .rst(rst), .din(ext_rst_n), .pulse(xir_ev));

  rtc_err_timer #(.LIMIT(ERR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(error_state), .done(err_done));

  rtc_arbiter #(.TL_W(TL_W), .MAX_TL(MAX_TL), .WDOG_TT(WDOG_TT)) u_arb (
    .por_ev(por_ev), .xir_ev(xir_ev), .wd_ev(wdog_tmo), .sir_ev(sir_req),
    .trq_ev(trap_req), .trq_tt(trap_tt), .tl(trap_level), .wd_pend(wd_pend),
    .in_err(error_state), .err_done(err_done), .v(v));

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid  <= 1'b0;
      trap_kind   <= KIND_NORMAL;
      trap_type   <= '0;
      trap_vector <= '0;
      red_state   <= 1'b0;
      error_state <= 1'b0;
      trap_level  <= '0;
      wd_pend     <= 1'b0;
    end else begin
      trap_valid <= v.fire;
      if (v.fire) begin
        trap_kind <= v.kind;
        trap_type <= v.tt;
        unique case (v.kind)
          KIND_RESET: begin
            trap_vector <= rst_base + (AW'(v.tt) << VEC_SHIFT);
            red_state   <= 1'b1;
            error_state <= 1'b0;
            trap_level  <= TL_MAX;
            wd_pend     <= 1'b0;
          end
          KIND_ERROR: begin
            trap_vector <= '0;
            error_state <= 1'b1;
          end
          default: begin
            trap_vector <= '0;
            trap_level  <= trap_level + 1'b1;
            if (v.from_wdog) wd_pend <= 1'b1;
          end
        endcase
      end else if (tl_load && !error_state) begin
        trap_level <= (tl_value > TL_MAX) ? TL_MAX : tl_value;
        red_state  <= 1'b0;
      end
    end
  end

  // R2: every reset trap lands in RED_state at the ceiling level
  assert_reset_enters_red_R2: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_kind == KIND_RESET) |-> (red_state && !error_state && trap_level == TL_MAX));
  // R11: reset traps only carry the four reset type codes
  assert_reset_type_range_R11: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_kind == KIND_RESET) |-> (trap_type >= TT_POR && trap_type <= TT_SIR));
  // R5: error_state is only ever entered with an error-entry pulse
  assert_error_entry_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(error_state) |-> (trap_valid && trap_kind == KIND_ERROR));
  // R10: error_state only ends with a reset trap
  assert_error_exit_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(error_state) |-> (trap_valid && trap_kind == KIND_RESET));
  // R6: a pass-through trap raises the level by exactly one
  assert_normal_level_step_R6: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_kind == KIND_NORMAL) |-> (trap_level == $past(trap_level) + 1'b1));
  // R13: level never exceeds the ceiling
  assert_level_bounded_R13: assert property (@(posedge clk) disable iff (rst)
    trap_level <= TL_MAX);
endmodule

// File: tb/reset_trap_ctrl_test.sv
module reset_trap_ctrl_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 32;
  localparam int          TL_W       = 3;
  localparam int          ERRC       = 6;
  localparam logic [7:0]  WDT        = 8'h46;
  localparam logic [31:0] BASE       = 32'h0001_0000;

  logic            clk = 1'b0;
  logic            rst;
  logic [AW-1:0]   rst_base;
  logic            por_hold, ext_rst_n, wdog_tmo, sir_req, trap_req, tl_load;
  logic [7:0]      trap_tt;
  logic [TL_W-1:0] tl_value;
  logic            trap_valid, red_state, error_state;
  logic [1:0]      trap_kind;
  logic [7:0]      trap_type;
  logic [AW-1:0]   trap_vector;
  logic [TL_W-1:0] trap_level;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_trap_ctrl #(.AW(AW), .TL_W(TL_W), .MAX_TL(5), .ERR_CYCLES(ERRC), .WDOG_TT(WDT)) uut (
    .clk(clk), .rst(rst), .rst_base(rst_base), .por_hold(por_hold), .ext_rst_n(ext_rst_n),
    .wdog_tmo(wdog_tmo), .sir_req(sir_req), .trap_req(trap_req), .trap_tt(trap_tt),
    .tl_load(tl_load), .tl_value(tl_value), .trap_valid(trap_valid), .trap_kind(trap_kind),
    .trap_type(trap_type), .trap_vector(trap_vector), .red_state(red_state),
    .error_state(error_state), .trap_level(trap_level));

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_trap(input string req, input logic [1:0] kind, input logic [7:0] tt,
                             input logic [31:0] vec);
    check(req, "valid", trap_valid, 1'b1);
    check(req, "kind", trap_kind, kind);
    check(req, "type", trap_type, tt);
    check(req, "vector", trap_vector, vec);
  endtask

  task automatic strobe(input logic wd, input logic sir, input logic trq, input logic [7:0] tt);
    wdog_tmo = wd; sir_req = sir; trap_req = trq; trap_tt = tt;
    @(negedge clk);
    wdog_tmo = 1'b0; sir_req = 1'b0; trap_req = 1'b0;
  endtask

  task automatic load_tl(input logic [TL_W-1:0] val);
    tl_load = 1'b1; tl_value = val;
    @(negedge clk);
    tl_load = 1'b0;
  endtask

  task automatic wait_wdr(input string req, input bit inject);
    for (int k = 1; k < ERRC; k++) begin
      if (inject && k == 1) begin
        wdog_tmo = 1'b1; sir_req = 1'b1; trap_req = 1'b1; trap_tt = 8'h11;
      end
      @(negedge clk);
      wdog_tmo = 1'b0; sir_req = 1'b0; trap_req = 1'b0;
      check(req, "no pulse in error_state", trap_valid, 1'b0);
      check(req, "error_state held", error_state, 1'b1);
    end
    @(negedge clk);
    expect_trap(req, 2'd1, 8'd2, BASE + 32'h40);
    check(req, "error_state left", error_state, 1'b0);
    check(req, "red after wdr", red_state, 1'b1);
  endtask

  task automatic t_reset();
    check("R1", "valid", trap_valid, 1'b0);
    check("R1", "red", red_state, 1'b0);
    check("R1", "error", error_state, 1'b0);
    check("R1", "level", trap_level, 3'd0);
  endtask

  task automatic t_por();
    por_hold = 1'b1;
    @(negedge clk);
    check("R2", "no trap while held", trap_valid, 1'b0);
    por_hold = 1'b0;
    @(negedge clk);
    expect_trap("R2", 2'd1, 8'd1, BASE + 32'h20);
    check("R2", "red", red_state, 1'b1);
    check("R2", "level", trap_level, 3'd5);
  endtask

  task automatic t_xir();
    load_tl(3'd1);
    check("R13", "red cleared by load", red_state, 1'b0);
    check("R13", "level loaded", trap_level, 3'd1);
    ext_rst_n = 1'b0;
    @(negedge clk);
    expect_trap("R3", 2'd1, 8'd3, BASE + 32'h60);
    check("R3", "red", red_state, 1'b1);
    @(negedge clk);
    check("R3", "held low gives no trap", trap_valid, 1'b0);
    ext_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sir_low();
    load_tl(3'd2);
    strobe(1'b0, 1'b1, 1'b0, 8'h00);
    expect_trap("R4", 2'd1, 8'd4, BASE + 32'h80);
    check("R4", "level", trap_level, 3'd5);
  endtask

  task automatic t_trap();
    load_tl(3'd7);
    check("R13", "clamp", trap_level, 3'd5);
    load_tl(3'd3);
    strobe(1'b0, 1'b0, 1'b1, 8'h29);
    expect_trap("R6", 2'd0, 8'h29, 32'h0);
    check("R6", "level up", trap_level, 3'd4);
    tl_load = 1'b1; tl_value = 3'd0;
    strobe(1'b0, 1'b0, 1'b1, 8'h2a);
    tl_load = 1'b0;
    expect_trap("R6", 2'd0, 8'h2a, 32'h0);
    check("R13", "load ignored with event", trap_level, 3'd5);
    strobe(1'b0, 1'b0, 1'b1, 8'h33);
    expect_trap("R7", 2'd2, 8'h33, 32'h0);
    check("R7", "error_state", error_state, 1'b1);
    wait_wdr("R10", 1'b1);
  endtask

  task automatic t_sir_max();
    strobe(1'b0, 1'b1, 1'b0, 8'h00);
    expect_trap("R5", 2'd2, 8'd4, 32'h0);
    check("R5", "error_state", error_state, 1'b1);
    wait_wdr("R5", 1'b0);
  endtask

  task automatic t_wdog();
    load_tl(3'd1);
    strobe(1'b1, 1'b0, 1'b0, 8'h00);
    expect_trap("R8", 2'd0, WDT, 32'h0);
    check("R8", "level up", trap_level, 3'd2);
    strobe(1'b1, 1'b0, 1'b0, 8'h00);
    expect_trap("R8", 2'd1, 8'd2, BASE + 32'h40);
    check("R8", "level", trap_level, 3'd5);
    strobe(1'b1, 1'b0, 1'b0, 8'h00);
    expect_trap("R9", 2'd1, 8'd2, BASE + 32'h40);
  endtask

  task automatic t_pend_clear();
    load_tl(3'd1);
    strobe(1'b1, 1'b0, 1'b0, 8'h00);
    expect_trap("R12", 2'd0, WDT, 32'h0);
    ext_rst_n = 1'b0;
    @(negedge clk);
    expect_trap("R12", 2'd1, 8'd3, BASE + 32'h60);
    ext_rst_n = 1'b1;
    @(negedge clk);
    load_tl(3'd1);
    strobe(1'b1, 1'b0, 1'b0, 8'h00);
    expect_trap("R12", 2'd0, WDT, 32'h0);
  endtask

  task automatic t_priority();
    por_hold = 1'b1;
    @(negedge clk);
    load_tl(3'd1);
    por_hold = 1'b0; ext_rst_n = 1'b0;
    strobe(1'b1, 1'b1, 1'b1, 8'h21);
    expect_trap("R11", 2'd1, 8'd1, BASE + 32'h20);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check("R11", "single pulse", trap_valid, 1'b0);
    load_tl(3'd1);
    ext_rst_n = 1'b0;
    strobe(1'b1, 1'b1, 1'b1, 8'h21);
    expect_trap("R11", 2'd1, 8'd3, BASE + 32'h60);
    ext_rst_n = 1'b1;
    @(negedge clk);
    load_tl(3'd1);
    strobe(1'b1, 1'b1, 1'b1, 8'h21);
    expect_trap("R11", 2'd0, WDT, 32'h0);
    load_tl(3'd1);
    strobe(1'b0, 1'b1, 1'b1, 8'h21);
    expect_trap("R11", 2'd1, 8'd4, BASE + 32'h80);
  endtask

  initial begin
    rst = 1'b1; rst_base = BASE; por_hold = 1'b0; ext_rst_n = 1'b1;
    wdog_tmo = 1'b0; sir_req = 1'b0; trap_req = 1'b0; trap_tt = 8'h00;
    tl_load = 1'b0; tl_value = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_por();
    t_xir();
    t_sir_low();
    t_trap();
    t_sir_max();
    t_wdog();
    t_pend_clear();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule